// File: doc/BRIEF.md
# Two-Slot TDMA Slot Timing Tracker

This block keeps local timeslot timing for a two-slot TDMA baseband. A counter advances on a 1 µs tick and marks a slot boundary every `SLOT_TICKS` ticks. At each boundary it raises a one-cycle slot interrupt and flips a slot index between 0 and 1. The counter runs while either the transmit or the receive enable is set. Both enables live in one 8-bit control word.

While receive is enabled, a pulse from the sync correlator that lands within `WIN_TICKS` of a local boundary pulls the local timing onto that sync, and the lock flag is set. A sync that lands later than the boundary restarts the counter without a second interrupt. A sync that lands early brings the boundary forward. If syncs stop, the block keeps producing interrupts from its own timing, and it drops the lock flag after two whole slots with no realignment. A frame-complete strobe from the deframer is turned into a frame interrupt at a fixed offset `T3_TICKS` into the following slot.

Top module: `slot_timer_top`

## Requirements
- R1: After a synchronous active-low reset, `slot_irq`, `frame_irq`, `locked` and `slot_idx` are all 0.
- R2: While `mode_ctl[7]` (transmit enable) or `mode_ctl[6]` (receive enable) is 1, the tick count starts at 0 and `slot_irq` gives a one-cycle pulse in the cycle after the tick that completes each group of `SLOT_TICKS` ticks.
- R3: `slot_idx` toggles in the same cycle as each `slot_irq` pulse, and at no other time.
- R4: A `sync_det` pulse with receive enabled, when the tick count is at most `WIN_TICKS`, restarts the count at 0 and produces no `slot_irq`.
- R5: A `sync_det` pulse with receive enabled, when the tick count is at least `SLOT_TICKS-WIN_TICKS`, gives `slot_irq` in the next cycle and restarts the count at 0. That slot gets no second pulse.
- R6: A `sync_det` pulse that falls outside both windows, or that arrives while receive is disabled, changes neither the timing nor `locked`.
- R7: `locked` goes to 1 in the cycle after a realignment. It goes to 0 at the second consecutive slot boundary reached with no realignment since the previous boundary.
- R8: With no sync, pulses continue on local timing while either enable is set. When both enables are 0, the count, `slot_idx`, `locked` and any pending frame interrupt are cleared, and no interrupt is produced.
- R9: A `frame_end` pulse yields one `frame_irq` pulse in the slot after the next boundary. The pulse comes in the cycle after the tick that takes the count from `T3_TICKS-1` to `T3_TICKS`.
- R10: The tick count advances only on cycles where `us_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ctl | input | 8 | Control word: bit 7 transmit enable, bit 6 receive enable, other bits unused |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| sync_det | input | 1 | Sync detected by the receive correlator |
| frame_end | input | 1 | Deframer finished a frame in the current slot |
| slot_irq | output | 1 | One-cycle slot boundary interrupt |
| slot_idx | output | 1 | Current slot number, 0 or 1 |
| locked | output | 1 | 1 when timing follows received sync |
| frame_irq | output | 1 | One-cycle frame interrupt, delayed to T3 of the next slot |

## Verification
The hardest state to reach from the ports is a sync placed exactly at a window edge, just before a natural boundary. Only there does an early boundary have to replace the natural one rather than add to it. The bench drives the stimulus from its own reference model's tick count: it waits until the modelled count equals a chosen value and then pulses `sync_det`. This places syncs at `SLOT_TICKS-10`, a few ticks past a boundary, and mid-slot. The same model runs a loss-of-sync sequence and a sparse-tick sequence, and every output is compared with the model on every cycle.

// File: rtl/slot_timer_pkg.sv
// Package: types and helpers shared by the slot timing tracker.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package slot_timer_pkg;

    // Why a slot boundary is taken this cycle
    typedef enum logic [1:0] {
        BND_NONE  = 2'd0,
        BND_WRAP  = 2'd1,
        BND_EARLY = 2'd2
    } bnd_cause_e;

    // Bits of the control word that carry the enables
    localparam int TX_EN_BIT = 7;
    localparam int RX_EN_BIT = 6;

endpackage

// File: rtl/slot_phase_cnt.sv
// Module: slot_phase_cnt
// Counts microsecond ticks within a slot, decides slot boundaries
// (natural wrap or early boundary pulled by sync) and realignment,
// and drives the registered slot interrupt and slot index.
// Assumes WIN_TICKS < SLOT_TICKS/2 so the two capture windows do not overlap.
module slot_phase_cnt
    import slot_timer_pkg::*;
#(
    parameter int SLOT_TICKS = 30000,
    parameter int WIN_TICKS  = 1250,
    localparam int CNT_W     = $clog2(SLOT_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             sync_ok,
    output logic [CNT_W-1:0] cnt,
    output logic             bnd_now,
    output logic             realign,
    output logic             irq,
    output logic             idx
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_TICKS - 1);
    localparam logic [CNT_W-1:0] LO_EDGE  = CNT_W'(WIN_TICKS);
    localparam logic [CNT_W-1:0] HI_EDGE  = CNT_W'(SLOT_TICKS - WIN_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             idx_q;
    logic             in_lo;
    logic             in_hi;
    bnd_cause_e       cause;

    // Classify the sync position and the boundary cause for this cycle
    always_comb begin
        in_lo   = cnt_q <= LO_EDGE;
        in_hi   = cnt_q >= HI_EDGE;
        realign = active && sync_ok && (in_lo || in_hi);
        if (!active)
            cause = BND_NONE;
        else if (sync_ok && in_hi && !in_lo)
            cause = BND_EARLY;
        else if (!realign && tick && cnt_q == LAST_CNT)
            cause = BND_WRAP;
        else
            cause = BND_NONE;
        bnd_now = cause != BND_NONE;
    end

    // Tick counter: hold at 0 when idle, restart on realign or boundary
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            cnt_q <= '0;
        else if (realign || bnd_now)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Slot interrupt pulse and slot index toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            irq_q <= 1'b0;
            idx_q <= 1'b0;
        end else begin
            irq_q <= bnd_now;
            if (bnd_now)
                idx_q <= ~idx_q;
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;
    assign idx = idx_q;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
    // R2
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R3
    idx_follows_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && idx_q != $past(idx_q)) |-> irq_q);
    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0 && !irq_q && !idx_q));

endmodule

// File: rtl/lock_monitor.sv
// Module: lock_monitor
// Tracks whether local timing follows received sync. Sets the lock on any
// realignment and clears it after LOSS_SLOTS boundaries in a row without one.
// Assumes bnd_now and realign come from slot_phase_cnt in the same cycle.
module lock_monitor #(
    parameter int LOSS_SLOTS = 2,
    localparam int MISS_W    = $clog2(LOSS_SLOTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bnd_now,
    input  logic realign,
    output logic locked
);
    localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(LOSS_SLOTS);

    logic              locked_q;
    logic              seen_q;
    logic [MISS_W-1:0] miss_q;

    // Lock state, per-slot sync-seen flag and saturating miss count
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            locked_q <= 1'b0;
            seen_q   <= 1'b0;
            miss_q   <= '0;
        end else if (realign) begin
            locked_q <= 1'b1;
            seen_q   <= 1'b1;
            miss_q   <= '0;
        end else if (bnd_now) begin
            seen_q <= 1'b0;
            if (seen_q)
                miss_q <= '0;
            else if (miss_q != MISS_MAX) begin
                miss_q <= miss_q + 1'b1;
                if (miss_q + 1'b1 == MISS_MAX)
                    locked_q <= 1'b0;
            end
        end
    end

    assign locked = locked_q;

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(realign));
    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked_q) && $past(active)) |-> $past(bnd_now));

endmodule

// File: rtl/frame_irq_sched.sv
// Module: frame_irq_sched
// Holds a frame-complete event until the next slot boundary, then fires a
// one-cycle frame interrupt when the tick count reaches T3_TICKS in that slot.
// Assumes WIN_TICKS < T3_TICKS < SLOT_TICKS - WIN_TICKS.
module frame_irq_sched #(
    parameter int SLOT_TICKS = 30000,
    parameter int T3_TICKS   = 2000,
    localparam int CNT_W     = $clog2(SLOT_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             bnd_now,
    input  logic             realign,
    input  logic [CNT_W-1:0] cnt,
    input  logic             frame_end,
    output logic             frame_irq
);
    localparam logic [CNT_W-1:0] FIRE_CNT = CNT_W'(T3_TICKS - 1);

    logic pend_q;
    logic arm_q;
    logic fire_q;
    logic fire;

    // Fire when armed and the count steps onto T3
    always_comb fire = arm_q && tick && !realign && !bnd_now && cnt == FIRE_CNT;

    // Pending flag (this slot) and armed flag (slot after the boundary)
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pend_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (bnd_now) begin
            arm_q  <= pend_q;
            pend_q <= frame_end;
        end else begin
            pend_q <= pend_q || frame_end;
            if (fire)
                arm_q <= 1'b0;
        end
    end

    // Registered frame interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            fire_q <= 1'b0;
        else
            fire_q <= fire;
    end

    assign frame_irq = fire_q;

    // R9
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    // R9
    frame_at_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (cnt == CNT_W'(T3_TICKS)));

endmodule

// File: rtl/slot_timer_top.sv
// Module: slot_timer_top
// Slot timing tracker for a two-slot TDMA baseband. Takes the enables from
// the control word, qualifies sync with the receive enable, and connects the
// phase counter, the lock monitor and the frame interrupt scheduler.
// Assumes us_tick, sync_det and frame_end are synchronous one-cycle pulses.
module slot_timer_top
    import slot_timer_pkg::*;
#(
    parameter int SLOT_TICKS = 30000,
    parameter int WIN_TICKS  = 1250,
    parameter int T3_TICKS   = 2000,
    parameter int LOSS_SLOTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] mode_ctl,
    input  logic       us_tick,
    input  logic       sync_det,
    input  logic       frame_end,
    output logic       slot_irq,
    output logic       slot_idx,
    output logic       locked,
    output logic       frame_irq
);
    localparam int CNT_W = $clog2(SLOT_TICKS);

    logic             tx_en;
    logic             rx_en;
    logic             active;
    logic             sync_ok;
    logic [CNT_W-1:0] cnt;
    logic             bnd_now;
    logic             realign;

    // Decode the enables and qualify sync with the receive enable
    always_comb begin
        tx_en   = mode_ctl[TX_EN_BIT];
        rx_en   = mode_ctl[RX_EN_BIT];
        active  = tx_en || rx_en;
        sync_ok = rx_en && sync_det;
    end

    slot_phase_cnt #(
        .SLOT_TICKS(SLOT_TICKS),
        .WIN_TICKS (WIN_TICKS)
    ) phase_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (us_tick),
        .sync_ok(sync_ok),
        .cnt    (cnt),
        .bnd_now(bnd_now),
        .realign(realign),
        .irq    (slot_irq),
        .idx    (slot_idx)
    );

    lock_monitor #(
        .LOSS_SLOTS(LOSS_SLOTS)
    ) lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .bnd_now(bnd_now),
        .realign(realign),
        .locked (locked)
    );

    frame_irq_sched #(
        .SLOT_TICKS(SLOT_TICKS),
        .T3_TICKS  (T3_TICKS)
    ) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (us_tick),
        .bnd_now  (bnd_now),
        .realign  (realign),
        .cnt      (cnt),
        .frame_end(frame_end),
        .frame_irq(frame_irq)
    );

    // R6
    no_sync_when_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en)) |-> !$rose(locked));

endmodule

// File: tb/slot_timer_top_tb.sv
module slot_timer_top_tb_top;
    localparam int SLOT = 200;
    localparam int WIN  = 20;
    localparam int T3   = 30;
    localparam int LOSS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_ctl = 8'h00;
    logic       us_tick = 1'b0;
    logic       sync_det = 1'b0;
    logic       frame_end = 1'b0;
    logic       slot_irq, slot_idx, locked, frame_irq;
    logic       gap_mode = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_miss = 0;
    bit m_idx = 0, m_lock = 0, m_seen = 0, m_pend = 0, m_arm = 0, m_irq = 0, m_firq = 0;

    always #2.5 clk = ~clk;

    slot_timer_top #(.SLOT_TICKS(SLOT), .WIN_TICKS(WIN), .T3_TICKS(T3), .LOSS_SLOTS(LOSS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_ctl(mode_ctl), .us_tick(us_tick),
        .sync_det(sync_det), .frame_end(frame_end), .slot_irq(slot_irq),
        .slot_idx(slot_idx), .locked(locked), .frame_irq(frame_irq));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        bit act, rx, ok, re, bnd, fire;
        act = mode_ctl[7] | mode_ctl[6];
        rx  = mode_ctl[6];
        if (!rst_n || !act) begin
            m_cnt = 0; m_idx = 0; m_lock = 0; m_miss = 0; m_seen = 0;
            m_pend = 0; m_arm = 0; m_irq = 0; m_firq = 0;
        end else begin
            ok = rx & sync_det;
            re = 0; bnd = 0;
            fire = m_arm && us_tick && (m_cnt == T3 - 1);
            if (ok && m_cnt <= WIN) begin re = 1; end
            else if (ok && m_cnt >= SLOT - WIN) begin re = 1; bnd = 1; end
            else if (us_tick && m_cnt == SLOT - 1) bnd = 1;
            if (re || bnd) begin fire = 0; m_cnt = 0; end
            else if (us_tick) m_cnt++;
            if (re) begin m_lock = 1; m_miss = 0; m_seen = 1; end
            else if (bnd) begin
                if (m_seen) m_miss = 0;
                else if (m_miss < LOSS) begin
                    m_miss++;
                    if (m_miss == LOSS) m_lock = 0;
                end
                m_seen = 0;
            end
            if (bnd) begin m_arm = m_pend; m_pend = frame_end; end
            else begin m_pend = m_pend | frame_end; if (fire) m_arm = 0; end
            m_irq = bnd;
            m_firq = fire;
            if (bnd) m_idx = ~m_idx;
        end
    end

    // compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 slot_irq", slot_irq, m_irq);
            chk("R3 slot_idx", slot_idx, m_idx);
            chk("R7 locked", locked, m_lock);
            chk("R9 frame_irq", frame_irq, m_firq);
        end
    end

    // microsecond tick: every cycle, or every other cycle in gap mode (R10)
    always @(negedge clk) us_tick <= gap_mode ? ~us_tick : 1'b1;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sync_at(input int c);
        while (m_cnt != c) @(negedge clk);
        sync_det = 1'b1;
        @(negedge clk);
        sync_det = 1'b0;
    endtask

    task automatic count_irq(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slot_irq) pulses++;
        end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!slot_irq && n < 5000);
    endtask

    initial begin
        int p, n;
        step(4);
        // R1: reset values
        chk("R1 slot_irq", slot_irq, 0);
        chk("R1 slot_idx", slot_idx, 0);
        chk("R1 locked", locked, 0);
        chk("R1 frame_irq", frame_irq, 0);
        rst_n = 1'b1;
        step(2);

        // R2: transmit enable only, free running
        mode_ctl = 8'h80;
        count_irq(450, p);
        chk("R2 pulses in 450 cycles", p, 2);

        // R6: sync with receive disabled is ignored
        sync_at(5);
        chk("R6 locked with rx off", locked, 0);

        // R4: late-side sync restarts count without a pulse
        mode_ctl = 8'h40;
        step(3);
        sync_at(5);
        chk("R4 no pulse at realign", slot_irq, 0);
        chk("R7 locked after realign", locked, 1);
        wait_irq(n);
        chk("R4 cycles to next boundary", n, SLOT);

        // R5: early-side sync brings the boundary forward
        sync_at(SLOT - 10);
        chk("R5 early pulse", slot_irq, 1);
        count_irq(SLOT - 1, p);
        chk("R5 no duplicate pulse", p, 0);

        // R6: mid-slot sync ignored
        sync_at(100);
        chk("R6 no pulse mid-slot", slot_irq, 0);

        // R9: frame complete, interrupt at T3 of the following slot
        step(10);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        count_irq(2 * SLOT, p);

        // R7/R8: sync stops, pulses continue, lock drops
        count_irq(3 * SLOT + 5, p);
        chk("R8 free-run pulses", p, 3);
        chk("R7 lock lost", locked, 0);

        // R10: sparse ticks stretch the slot
        gap_mode = 1'b1;
        wait_irq(n);
        wait_irq(n);
        chk("R10 cycles per slot with half-rate tick", n, 2 * SLOT);
        gap_mode = 1'b0;

        // R8: both enables cleared
        mode_ctl = 8'h3F;
        count_irq(3 * SLOT, p);
        chk("R8 no pulses when idle", p, 0);
        chk("R8 idx cleared", slot_idx, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule